// File: doc/BRIEF.md
# Shared-Bus Repeated-Addition Multiplier

This block multiplies two unsigned words by adding the multiplicand into an accumulator once for every count of the multiplier. Both operands arrive one after the other over a single input bus. The cycle that launches an operation carries the multiplicand, and the cycle after it carries the multiplier. A small controller then steps a loop in which one addition and one decrement of the multiplier count happen together in each cycle. The loop ends when the count reaches zero.

When the loop is finished, the product is placed on the output bus for exactly one clock period, marked by a valid strobe. The controller then parks in a halted state and raises `done`, which stays high until the next launch. The product is kept to the word width (modulo 2^W). Any carry out of the adder is dropped. A multiplier of zero skips the loop entirely. A launch request is only taken while the block is idle or halted.

Top module: `seqadd_mult`

## Requirements
- R1: After reset the block is idle: `outbus` is 0, `out_vld` is 0 and `done` is 0, and they stay so while `start` is low.
- R2: While idle or halted, a high `start` at a clock edge launches an operation. The accumulator is cleared and `inbus` at that edge is taken as the multiplicand.
- R3: At the clock edge that follows the launch, `inbus` is taken as the multiplier count.
- R4: The presented product equals (multiplicand × multiplier) mod 2^W, with W = 8 by default. The adder carry is discarded.
- R5: `out_vld` is high exactly in the cycle after the clock edge that is (multiplier + 2) edges after the launch edge, and it is low in all earlier cycles of the operation.
- R6: A multiplier of zero gives a product of 0 after 2 edges, with no wrap of the count.
- R7: `out_vld` lasts one cycle. `outbus` is 0 whenever `out_vld` is low.
- R8: `done` is low from the launch edge onward and rises together with the end of the `out_vld` cycle. It then stays high until the next launch.
- R9: `start` and `inbus` have no effect while an operation is in progress after the multiplier has been loaded. The product and the latency are unchanged.
- R10: A launch from the halted state starts from a cleared accumulator, so no earlier product leaks into the new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Launch request, sampled only while idle or halted |
| inbus | input | W | Shared operand bus: multiplicand at launch, multiplier one cycle later |
| outbus | output | W | Product while `out_vld` is high, otherwise 0 |
| out_vld | output | 1 | One-cycle strobe marking the product on `outbus` |
| done | output | 1 | High in the halted state until the next launch |

## Verification
The bench sweeps every pair of 4-bit operands and also runs boundary multipliers (0, 1, 128, 254, 255) and random pairs. A zero multiplier catches a count that wraps; such a design would loop 256 times and report a wrong product late. Large products catch an adder that keeps its carry or an accumulator that is not cleared between operations, since either shows up as a wrong value mod 256. The bench checks the exact cycle of the strobe, so a design that swaps which bus cycle feeds the counter shows a wrong latency. Noise on `start` and `inbus` during the loop exposes a controller that resamples the bus or relaunches mid-operation.

// File: rtl/seqadd_pkg.sv
package seqadd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LDQ  = 3'd1,
    ST_LOOP = 3'd2,
    ST_OUT  = 3'd3,
    ST_HALT = 3'd4
  } seqadd_state_e;

  // control points driven by the sequencer into the datapath
  typedef struct packed {
    logic a_clr;   // clear accumulator
    logic m_ld;    // capture multiplicand from the bus
    logic q_ld;    // capture multiplier count from the bus
    logic step;    // accumulate and decrement together
    logic out_en;  // present accumulator on the output bus
  } seqadd_ctl_t;

endpackage

// File: rtl/seqadd_rst_sync.sv
module seqadd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/seqadd_adder.sv
module seqadd_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);

  // ripple chain; the carry out of the top bit is never formed
  logic [W-1:0] carry;
  assign carry[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i] = a[i] ^ b[i] ^ carry[i];
    if (i < W - 1) begin : g_carry
      assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
    end
  end

endmodule

// File: rtl/seqadd_dpath.sv
module seqadd_dpath
  import seqadd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  seqadd_ctl_t ctl,
  input  logic [W-1:0] inbus,
  output logic [W-1:0] outbus,
  output logic        q_zero
);

  logic [W-1:0] acc_q, mcand_q, cnt_q;
  logic [W-1:0] sum;

  seqadd_adder #(.W(W)) u_add (
    .a   (acc_q),
    .b   (mcand_q),
    .sum (sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         acc_q <= '0;
    else if (ctl.a_clr) acc_q <= '0;
    else if (ctl.step)  acc_q <= sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mcand_q <= '0;
    else if (ctl.m_ld) mcand_q <= inbus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (ctl.q_ld) cnt_q <= inbus;
    else if (ctl.step) cnt_q <= cnt_q - 1'b1;
  end

  assign q_zero = (cnt_q == '0);
  assign outbus = ctl.out_en ? acc_q : '0;

  // R4
  acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.step |=> acc_q == W'($past(acc_q) + $past(mcand_q)));

  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.step |-> cnt_q != '0);

  // R10
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.a_clr |=> acc_q == '0);

  // R9
  mcand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.m_ld |=> $stable(mcand_q));

endmodule

// File: rtl/seqadd_ctrl.sv
module seqadd_ctrl
  import seqadd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        q_zero,
  output seqadd_ctl_t ctl,
  output logic        out_vld,
  output logic        done
);

  seqadd_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    ctl     = '0;
    unique case (state_q)
      ST_IDLE, ST_HALT: begin
        if (start) begin
          ctl.a_clr = 1'b1;
          ctl.m_ld  = 1'b1;
          state_d   = ST_LDQ;
        end
      end
      ST_LDQ: begin
        ctl.q_ld = 1'b1;
        state_d  = ST_LOOP;
      end
      ST_LOOP: begin
        if (q_zero) state_d  = ST_OUT;
        else        ctl.step = 1'b1;
      end
      ST_OUT: begin
        ctl.out_en = 1'b1;
        state_d    = ST_HALT;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign out_vld = (state_q == ST_OUT);
  assign done    = (state_q == ST_HALT);

  // R7
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |=> !out_vld);

  // R8
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |=> done);

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  // R8
  done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && start |=> !done);

endmodule

// File: rtl/seqadd_mult.sv
module seqadd_mult
  import seqadd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] inbus,
  output logic [W-1:0] outbus,
  output logic         out_vld,
  output logic         done
);

  logic        rst_n_s;
  logic        q_zero;
  seqadd_ctl_t ctl;

  seqadd_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  seqadd_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .start   (start),
    .q_zero  (q_zero),
    .ctl     (ctl),
    .out_vld (out_vld),
    .done    (done)
  );

  seqadd_dpath #(.W(W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .ctl    (ctl),
    .inbus  (inbus),
    .outbus (outbus),
    .q_zero (q_zero)
  );

  // R7
  outbus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !out_vld |-> outbus == '0);

  // R8
  vld_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(out_vld && done));

endmodule

// File: tb/seqadd_mult_tb.sv
module seqadd_mult_tb;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [W-1:0] inbus;
  logic [W-1:0] outbus;
  logic         out_vld;
  logic         done;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  seqadd_mult #(.W(W)) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .inbus   (inbus),
    .outbus  (outbus),
    .out_vld (out_vld),
    .done    (done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // launch one operation and check strobe cycle, product and halt behaviour
  task automatic run_op(input int a, input int b, input bit noisy, input string ptag);
    int  exp_p;
    int  early;
    exp_p = (a * b) % 256;
    early = 0;
    @(negedge clk);
    start = 1'b1;
    inbus = W'(a);
    @(negedge clk);                       // after launch edge
    chk(done == 1'b0, "R8 done low after launch", int'(done), 0);
    start = 1'b0;
    inbus = W'(b);                        // R3 multiplier on second cycle
    for (int k = 1; k <= b + 2; k++) begin
      @(negedge clk);
      if (k < b + 2 && out_vld) early++;
      if (k < b + 2 && noisy) begin
        inbus = W'($urandom);
        start = (k <= b + 1) ? 1'($urandom) : 1'b0;
      end else begin
        inbus = W'($urandom);
        start = 1'b0;
      end
    end
    chk(early == 0, (b == 0) ? "R6 early strobe" : "R3 R5 early strobe", early, 0);
    chk(out_vld == 1'b1, (b == 0) ? "R6 strobe cycle" : "R3 R5 strobe cycle", int'(out_vld), 1);
    chk(int'(outbus) == exp_p, ptag, int'(outbus), exp_p);
    @(negedge clk);
    chk(out_vld == 1'b0 && outbus == '0, "R7 strobe one cycle", int'(outbus), 0);
    chk(done == 1'b1, "R8 done after strobe", int'(done), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    inbus = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state, idle with start low
    for (int i = 0; i < 3; i++) begin
      chk(outbus == '0 && out_vld == 1'b0, "R1 idle outputs", int'(outbus) + int'(out_vld), 0);
      chk(done == 1'b0, "R1 done low in idle", int'(done), 0);
      inbus = 8'hA5;
      @(negedge clk);
    end

    // R2 R4 R6 R9 exhaustive 4-bit sweep
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        run_op(a, b, a[0], a[0] ? "R9 product with bus noise" : "R2 R4 product");

    // R6 zero multiplier with large multiplicand
    run_op(255, 0, 1'b0, "R6 zero product");

    // R4 boundary multipliers, carry discard
    run_op(255, 255, 1'b0, "R4 product 255x255");
    run_op(200, 254, 1'b1, "R9 product 200x254");
    run_op(3, 128, 1'b0, "R4 product 3x128");
    run_op(128, 2, 1'b0, "R4 carry dropped 128x2");
    run_op(17, 1, 1'b0, "R4 product x1");

    // R10 fresh accumulator after a large product
    run_op(250, 3, 1'b0, "R4 product 250x3");
    run_op(7, 2, 1'b0, "R10 cleared accumulator");

    // R8 done holds while halted and start low
    repeat (5) begin
      @(negedge clk);
      chk(done == 1'b1 && out_vld == 1'b0, "R8 done holds", int'(done), 1);
    end

    // random pairs
    for (int i = 0; i < 40; i++) begin
      int ra;
      int rb;
      ra = int'($urandom % 256);
      rb = int'($urandom % 256);
      run_op(ra, rb, i[0], "R4 random product");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule